// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port on an APB-style register bus. Each pin is either an input or an output, set by a direction register. Output pins drive the value held in an output latch. Input pins are sampled through a two-stage synchroniser.

Access to the data register goes through a 256-word address window. Address bits [9:2] of each access form a per-bit mask. A write changes only the latch bits whose mask bit is set. Software can therefore set or clear one pin with a single store and no read-modify-write. A read of the window returns, for each bit, either the latched value (output pins) or the synchronised pin level (input pins). Bits outside the mask read as zero.

Wider ports are built from several instances of this block side by side.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is held, the direction register and the output latch are 0, so `pin_oe` and `pin_out` are 0 and the direction register reads 0.
- R2: The data window covers the word-aligned offsets 0x000 to 0x3FC. Mask bit n of a data access is address bit n+2, for example offset 0x080 selects bit 5 only.
- R3: A data write sets each latch bit whose mask bit is 1 to the matching `pwdata` bit. Every latch bit whose mask bit is 0 keeps its value.
- R4: In a data read, every bit whose mask bit is 0 returns 0.
- R5: In a data read of an unmasked bit, a pin whose direction bit is 1 returns its latch bit, and a pin whose direction bit is 0 returns its synchronised input.
- R6: The direction register is at offset 0x400. A direction bit of 1 makes the pin an output. All eight bits are written and read with no mask.
- R7: `pin_oe` equals the direction register, and `pin_out` equals the latch ANDed with the direction register.
- R8: A level on `pin_in` that is sampled at a rising edge first appears in `prdata` after the next rising edge, which is two edges of latency.
- R9: The following are unmapped: offsets above 0x400, and offsets whose two low bits are not zero. An unmapped read returns 0 and an unmapped write changes nothing. `prdata` is 0 whenever no read is selected.
- R10: `pready` is always 1. A write takes effect at the rising edge where `psel`, `penable` and `pwrite` are all 1. A setup phase alone (`penable` low) changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address; bits [9:2] are the data mask |
| pwdata | input | NPIN | Write data |
| prdata | output | NPIN | Read data |
| pready | output | 1 | Always 1 |
| pin_in | input | NPIN | Asynchronous pin inputs |
| pin_out | output | NPIN | Pin output values |
| pin_oe | output | NPIN | Pin output enables |

## Verification
The assertions check the following on every cycle:
- unmasked latch bits are preserved across a data write, and masked bits are loaded;
- masked-off read bits are zero;
- `pin_out` is zero wherever `pin_oe` is zero;
- unmapped reads return zero;
- setup-only cycles leave the registers unchanged;
- with all pins as inputs, read data trails the pins by exactly two samples.

Only the bench scenarios can show the following:
- the exact mix of latched and sampled bits under a mixed direction setting;
- the mapping of individual address bits to pins;
- that a full sequence of set and clear stores leaves the pins in the intended state.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [NPIN-1:0]   pwdata,
  output logic [NPIN-1:0]   prdata,
  output logic              pready,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe
);
  localparam int MSK_HI = NPIN + 1;
  localparam logic [ADDR_W-1:0] DIR_OFF = ADDR_W'(1) << (NPIN + 2);

  logic [NPIN-1:0] lat, dir, sync1, sync2, msk, mixed;
  logic data_hit, dir_hit, wr_en, rd_en;

  assign msk      = paddr[MSK_HI:2];
  assign data_hit = (paddr[ADDR_W-1:NPIN+2] == '0) && (paddr[1:0] == 2'b00);
  assign dir_hit  = (paddr == DIR_OFF);
  assign wr_en    = psel & penable & pwrite;
  assign rd_en    = psel & ~pwrite;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= '0;
      dir <= '0;
    end else begin
      if (wr_en && data_hit) lat <= (lat & ~msk) | (pwdata & msk);
      if (wr_en && dir_hit)  dir <= pwdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  assign mixed = (lat & dir) | (sync2 & ~dir);

  always_comb begin
    prdata = '0;
    if (rd_en) begin
      if (data_hit)     prdata = mixed & msk;
      else if (dir_hit) prdata = dir;
    end
  end

  assign pin_oe  = dir;
  assign pin_out = lat & dir;
  assign pready  = 1'b1;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [NPIN-1:0]   pwdata,
  input logic [NPIN-1:0]   prdata,
  input logic [NPIN-1:0]   pin_in,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   lat,
  input logic [NPIN-1:0]   dir
);
  localparam logic [ADDR_W-1:0] DIR_OFF = ADDR_W'(1) << (NPIN + 2);
  logic [NPIN-1:0] m;
  logic in_win;
  logic [1:0] since_rst;

  assign m      = paddr[NPIN+1:2];
  assign in_win = (paddr < DIR_OFF) && (paddr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  // R3
  wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && in_win) |=> ((lat & ~$past(m)) == ($past(lat) & ~$past(m))));
  // R3
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && in_win) |=> ((lat & $past(m)) == ($past(pwdata) & $past(m))));
  // R4
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && in_win) |-> ((prdata & ~m) == '0));
  // R7
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0));
  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && !in_win && paddr != DIR_OFF) |-> (prdata == '0));
  // R10
  setup_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> ($stable(dir) && $stable(lat)));
  // R8
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && psel && !pwrite && in_win && dir == '0 && m == '1)
      |-> (prdata == $past(pin_in, 2)));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .lat(lat), .dir(dir)
);

// File: tb/gpio_mask_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mask_port_tb_top;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [7:0] pwdata = '0, pin_in = '0;
  logic [7:0] prdata, pin_out, pin_oe;
  logic pready;
  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  gpio_mask_port dut_i (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  // behavioural reference
  bit [7:0] m_lat, m_dir;
  bit [7:0] m_q[$] = '{8'h00, 8'h00};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat = 0; m_dir = 0; m_q = '{8'h00, 8'h00};
    end else begin
      if (psel && penable && pwrite) begin
        if (paddr < 12'h400 && paddr % 4 == 0) begin
          for (int b = 0; b < 8; b++) if (paddr[b+2]) m_lat[b] = pwdata[b];
        end else if (paddr == 12'h400) m_dir = pwdata;
      end
      m_q.push_back(pin_in);
      void'(m_q.pop_front());
    end
  end

  function automatic bit [7:0] model_rd();
    int a = paddr;
    if (!(psel && !pwrite)) return 0;
    if (a < 'h400 && a % 4 == 0) return ((m_lat & m_dir) | (m_q[0] & ~m_dir)) & 8'(a >> 2);
    if (a == 'h400) return m_dir;
    return 0;
  endfunction

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    chk("R7", pin_oe, m_dir);
    chk("R7", pin_out, m_lat & m_dir);
    chk(tag, prdata, model_rd());
    chk("R10", {7'd0, pready}, 8'd1);
  end

  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [7:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    #1 chk("R1", pin_oe, 8'h00); chk("R1", pin_out, 8'h00);
    rst_n = 1;
    rd(12'h400, v); chk("R1", v, 8'h00);
    tag = "R6";
    wr(12'h400, 8'h0F); rd(12'h400, v); chk("R6", v, 8'h0F);
    chk("R7", pin_oe, 8'h0F);
    tag = "R3";
    wr(12'h3FC, 8'hFF); chk("R3", pin_out, 8'h0F);
    wr(12'h008, 8'h00); chk("R3", pin_out, 8'h0D);
    tag = "R4";
    rd(12'h004, v); chk("R4", v, 8'h01);
    rd(12'h008, v); chk("R4", v, 8'h00);
    tag = "R5";
    pin_in = 8'hA0; repeat (3) @(negedge clk);
    rd(12'h3FC, v); chk("R5", v, 8'hAD);
    tag = "R8";
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = 12'h3FC; pin_in = 8'h50;
    @(negedge clk); #1 chk("R8", prdata, 8'hAD);
    @(negedge clk); #1 chk("R8", prdata, 8'h5D);
    @(negedge clk); psel = 0;
    tag = "R9";
    wr(12'h800, 8'hFF); wr(12'h404, 8'hFF); wr(12'h3FE, 8'h00);
    rd(12'h400, v); chk("R9", v, 8'h0F); chk("R9", pin_out, 8'h0D);
    rd(12'h800, v); chk("R9", v, 8'h00);
    rd(12'h3FD, v); chk("R9", v, 8'h00);
    tag = "R10";
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h400; pwdata = 8'hFF;
    @(negedge clk); psel = 0; pwrite = 0;
    rd(12'h400, v); chk("R10", v, 8'h0F);
    tag = "R2";
    wr(12'h400, 8'hFF); chk("R2", pin_out, 8'hFD);
    wr(12'h080, 8'h00); chk("R2", pin_out, 8'hDD);
    rd(12'h080, v); chk("R2", v, 8'h00);
    rd(12'h040, v); chk("R2", v, 8'h10);
    tag = "R1";
    @(negedge clk); rst_n = 0;
    #1 chk("R1", pin_oe, 8'h00); chk("R1", pin_out, 8'h00);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    done = 1;
    finish_up();
  end
endmodule